// File: doc/BRIEF.md
# Sparse GF(2) Matrix-Vector Multiplier

This block computes y = H·x over GF(2) for a sparse binary matrix H that is never held as a bit array. H is described by two parallel external memories that share one address: an index memory holding the column number of every nonzero position, row after row, and a one-bit marker memory whose entry is 1 exactly where the index at the same address is the final one of its row. The block walks both memories from address 0, fetches the addressed bits of x from an external vector memory, folds them together with XOR per row, and writes one result bit per row to an output vector port.

A run is launched with a single-cycle `start` pulse that carries the number of rows. All three memories return data one cycle after a read request. The block overlaps the request of one entry with the vector read of the previous one, so it consumes one index per clock. Completion is signalled with a one-cycle `done` pulse. Rows without entries must not appear in the list. The top module is part of a larger encoder datapath in which matrix generation happens elsewhere.

Top module: `smv_gf2_mul`

## Requirements
- R1: Each written output bit equals the XOR of the vector bits at the column indices listed for that row.
- R2: Rows are separated only by marker bits: marker 1 ends a row, marker 0 continues it. The accumulator starts cleared for every row, so a row with a single entry outputs exactly that vector bit.
- R3: Output rows are written once each, in ascending order at addresses 0 to rows-1, with out_we high for one cycle per row.
- R4: One list entry is consumed per clock. If start is sampled at edge k, the row whose last entry sits at list address j is written at edge k+3+j.
- R5: done is high for exactly one cycle, at the edge after the final row write (edge k+3+E for E list entries), and no write follows it.
- R6: A start pulse arriving while a run is in progress, up to and including the done cycle, is ignored: the rows count and results of the ongoing run are unchanged.
- R7: A start with rows equal to 0 reads nothing, writes nothing, and raises done at the edge after start is sampled.
- R8: After reset, done, out_we, idx_rd and vec_rd are low.
- R9: The index and marker memories are read exactly E times per run, at addresses 0 to E-1, and no entry after the final row's marker is fetched.
- R10: The index address space spans IDX_DEPTH entries, 8192 by default, and the fetch address never reaches IDX_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle launch pulse |
| rows | input | RW | Number of matrix rows for this run, sampled with start |
| done | output | 1 | One-cycle completion pulse |
| idx_rd | output | 1 | Read request to index and marker memories |
| idx_addr | output | IW | Shared address of index and marker memories |
| idx_rdata | input | CW | Column index returned one cycle after idx_rd |
| mrk_rdata | input | 1 | End-of-row marker returned one cycle after idx_rd |
| vec_rd | output | 1 | Read request to the input vector memory |
| vec_addr | output | CW | Input vector bit address |
| vec_rdata | input | 1 | Vector bit returned one cycle after vec_rd |
| out_we | output | 1 | Output vector write strobe |
| out_addr | output | AW | Output row address |
| out_bit | output | 1 | Output bit value |

## Verification
The two functions that share a cycle are the closing write of one row and the first accumulation of the next: with one entry per clock, the cycle that registers a row's result also receives the next row's first vector bit, so a stale accumulator would leak into the next row. This is provoked with lists made wholly of single-entry rows and with mixed short and long rows, and judged by comparing every cycle's write strobe, address and bit against a reference computed in the bench from the lists and the vector. A second overlap, a new start landing on a running job, is provoked mid-run and judged by the unchanged schedule of the job in flight.

// File: rtl/smv_pkg.sv
package smv_pkg;

    // Tag travelling with a list entry through the read pipeline
    typedef struct packed {
        logic vld;   // entry present in this stage
        logic last;  // entry closes its row
    } smv_tag_t;

    // GF(2) addition
    function automatic logic gf2_add(input logic a, input logic b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/smv_fetch.sv
module smv_fetch
    import smv_pkg::*;
#(
    parameter int IDX_DEPTH = 8192,
    parameter int MAX_ROWS  = 2304,
    localparam int IW = $clog2(IDX_DEPTH),
    localparam int RW = $clog2(MAX_ROWS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [RW-1:0] rows,
    input  logic          mrk_rdata,
    input  logic          done,
    output logic          mem_rd,
    output logic [IW-1:0] mem_addr,
    output smv_tag_t      s1_tag,
    output logic [RW-1:0] rows_q,
    output logic          start_acc,
    output logic          zero_req
);

    logic          run;
    logic          fetch_on;
    logic [IW:0]   ptr;
    logic [RW-1:0] marks;
    logic          final_mark;

    assign start_acc  = start && !run;
    assign final_mark = s1_tag.vld && mrk_rdata && (marks == rows_q - RW'(1));
    assign mem_rd     = fetch_on && !final_mark;
    assign mem_addr   = ptr[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            fetch_on <= 1'b0;
            ptr      <= '0;
            marks    <= '0;
            rows_q   <= '0;
            zero_req <= 1'b0;
            s1_tag   <= '0;
        end else begin
            zero_req   <= 1'b0;
            s1_tag.vld <= mem_rd;
            s1_tag.last <= 1'b0;
            if (start_acc) begin
                rows_q <= rows;
                ptr    <= '0;
                marks  <= '0;
                if (rows == '0) begin
                    zero_req <= 1'b1;
                end else begin
                    run      <= 1'b1;
                    fetch_on <= 1'b1;
                end
            end else begin
                if (mem_rd) ptr <= ptr + 1'b1;
                if (s1_tag.vld && mrk_rdata) marks <= marks + 1'b1;
                if (final_mark) fetch_on <= 1'b0;
                if (done) run <= 1'b0;
            end
        end
    end

    // R10: fetch address stays inside the index memory
    a_r10_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (ptr < (IW+1)'(IDX_DEPTH)));

    // R6: a run's row count does not change under a second start
    a_r6_rows_hold: assert property (@(posedge clk) disable iff (rst)
        (run && start) |=> $stable(rows_q));

    // R9: nothing is fetched once the final marker has been seen
    a_r9_stop_after_last: assert property (@(posedge clk) disable iff (rst)
        final_mark |=> !s1_tag.vld);

endmodule

// File: rtl/smv_accum.sv
module smv_accum
    import smv_pkg::*;
#(
    parameter int MAX_ROWS = 2304,
    localparam int RW = $clog2(MAX_ROWS + 1),
    localparam int AW = $clog2(MAX_ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  smv_tag_t      s1_tag,
    input  logic          s1_mark,
    input  logic          vec_rdata,
    input  logic [RW-1:0] rows_q,
    input  logic          start_acc,
    input  logic          zero_req,
    output logic          out_we,
    output logic [AW-1:0] out_addr,
    output logic          out_bit,
    output logic          done
);

    smv_tag_t      s2_tag;
    logic          acc;
    logic [AW-1:0] row_ctr;
    logic          sum;

    assign sum = gf2_add(acc, vec_rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_tag   <= '0;
            acc      <= 1'b0;
            row_ctr  <= '0;
            out_we   <= 1'b0;
            out_addr <= '0;
            out_bit  <= 1'b0;
            done     <= 1'b0;
        end else begin
            s2_tag.vld  <= s1_tag.vld;
            s2_tag.last <= s1_tag.vld && s1_mark;
            out_we      <= 1'b0;
            done        <= zero_req ||
                           (out_we && (RW'(out_addr) == rows_q - RW'(1)));
            if (start_acc) begin
                row_ctr <= '0;
                acc     <= 1'b0;
            end else if (s2_tag.vld) begin
                if (s2_tag.last) begin
                    out_we   <= 1'b1;
                    out_bit  <= sum;
                    out_addr <= row_ctr;
                    row_ctr  <= row_ctr + 1'b1;
                    acc      <= 1'b0;
                end else begin
                    acc <= sum;
                end
            end
        end
    end

    // R5: done lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: done follows the final write, or an empty job
    a_r5_done_after_write: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(out_we) || $past(zero_req)));

    // R3: back-to-back writes go to consecutive rows
    a_r3_rows_ascend: assert property (@(posedge clk) disable iff (rst)
        (out_we && $past(out_we)) |-> (out_addr == $past(out_addr) + 1'b1));

    // R5: no write in the cycle after done
    a_r5_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !out_we);

endmodule

// File: rtl/smv_gf2_mul.sv
module smv_gf2_mul
    import smv_pkg::*;
#(
    parameter int IDX_DEPTH = 8192,
    parameter int VEC_LEN   = 2304,
    parameter int MAX_ROWS  = 2304,
    localparam int IW = $clog2(IDX_DEPTH),
    localparam int CW = $clog2(VEC_LEN),
    localparam int RW = $clog2(MAX_ROWS + 1),
    localparam int AW = $clog2(MAX_ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [RW-1:0] rows,
    output logic          done,
    output logic          idx_rd,
    output logic [IW-1:0] idx_addr,
    input  logic [CW-1:0] idx_rdata,
    input  logic          mrk_rdata,
    output logic          vec_rd,
    output logic [CW-1:0] vec_addr,
    input  logic          vec_rdata,
    output logic          out_we,
    output logic [AW-1:0] out_addr,
    output logic          out_bit
);

    smv_tag_t      s1_tag;
    logic [RW-1:0] rows_q;
    logic          start_acc;
    logic          zero_req;

    smv_fetch #(.IDX_DEPTH(IDX_DEPTH), .MAX_ROWS(MAX_ROWS)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rows      (rows),
        .mrk_rdata (mrk_rdata),
        .done      (done),
        .mem_rd    (idx_rd),
        .mem_addr  (idx_addr),
        .s1_tag    (s1_tag),
        .rows_q    (rows_q),
        .start_acc (start_acc),
        .zero_req  (zero_req)
    );

    // Stage 1: the returned column index addresses the vector memory
    assign vec_rd   = s1_tag.vld;
    assign vec_addr = idx_rdata;

    smv_accum #(.MAX_ROWS(MAX_ROWS)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .s1_tag    (s1_tag),
        .s1_mark   (mrk_rdata),
        .vec_rdata (vec_rdata),
        .rows_q    (rows_q),
        .start_acc (start_acc),
        .zero_req  (zero_req),
        .out_we    (out_we),
        .out_addr  (out_addr),
        .out_bit   (out_bit),
        .done      (done)
    );

    // R8: no activity at the ports while reset is applied
    always_ff @(posedge clk) begin
        if (!rst && $past(rst)) begin
            a_r8_idle_after_reset: assert (!done && !out_we && !vec_rd);
        end
    end

endmodule

// File: tb/smv_gf2_mul_test.sv
module smv_gf2_mul_test;

    localparam int IDX_DEPTH = 64;
    localparam int VEC_LEN   = 32;
    localparam int MAX_ROWS  = 16;
    localparam int IW = $clog2(IDX_DEPTH);
    localparam int CW = $clog2(VEC_LEN);
    localparam int RW = $clog2(MAX_ROWS + 1);
    localparam int AW = $clog2(MAX_ROWS);
    localparam int WIN = IDX_DEPTH + 8;

    logic clk = 0;
    logic rst = 1;
    logic start = 0;
    logic [RW-1:0] rows = '0;
    logic done, idx_rd, vec_rd, out_we, out_bit;
    logic [IW-1:0] idx_addr;
    logic [CW-1:0] idx_rdata, vec_addr;
    logic mrk_rdata, vec_rdata;
    logic [AW-1:0] out_addr;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [CW-1:0] idx_mem [IDX_DEPTH];
    logic          mrk_mem [IDX_DEPTH];
    logic          vec_mem [VEC_LEN];

    // expected events per cycle offset from the start edge
    logic          e_we   [WIN];
    logic [AW-1:0] e_addr [WIN];
    logic          e_bit  [WIN];
    logic          e_done [WIN];

    always #2.5 clk = ~clk;

    smv_gf2_mul #(.IDX_DEPTH(IDX_DEPTH), .VEC_LEN(VEC_LEN), .MAX_ROWS(MAX_ROWS)) uut (
        .clk(clk), .rst(rst), .start(start), .rows(rows), .done(done),
        .idx_rd(idx_rd), .idx_addr(idx_addr), .idx_rdata(idx_rdata),
        .mrk_rdata(mrk_rdata), .vec_rd(vec_rd), .vec_addr(vec_addr),
        .vec_rdata(vec_rdata), .out_we(out_we), .out_addr(out_addr), .out_bit(out_bit)
    );

    // memories with one-cycle read latency
    always @(posedge clk) begin
        if (idx_rd) begin
            idx_rdata <= idx_mem[idx_addr];
            mrk_rdata <= mrk_mem[idx_addr];
        end
        if (vec_rd) vec_rdata <= vec_mem[vec_addr];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Row lengths in lens[0..nrows-1]; columns taken from seed.
    task automatic load(input int nrows, input int lens[$], input int seed);
        int p = 0;
        for (int r = 0; r < nrows; r++) begin
            for (int k = 0; k < lens[r]; k++) begin
                idx_mem[p] = CW'((seed * 7 + p * 13 + r * 5 + k * 3) % VEC_LEN);
                mrk_mem[p] = (k == lens[r] - 1);
                p++;
            end
        end
        for (int q = p; q < IDX_DEPTH; q++) begin
            idx_mem[q] = CW'(q % VEC_LEN);
            mrk_mem[q] = 1'b1;
        end
    endtask

    // Reference: walk the list behaviourally, then compare every cycle.
    task automatic run(input int nrows, input int nent, input bit inject, input string tag);
        int reads = 0;
        int rsum = 0;
        int r = 0;
        int last_done = (nrows == 0) ? 1 : nent + 3;
        for (int o = 0; o < WIN; o++) begin
            e_we[o] = 0; e_addr[o] = '0; e_bit[o] = 0; e_done[o] = 0;
        end
        for (int j = 0; j < nent; j++) begin
            rsum = rsum ^ int'(vec_mem[idx_mem[j]]);
            if (mrk_mem[j]) begin
                e_we[j + 3] = 1; e_addr[j + 3] = AW'(r); e_bit[j + 3] = rsum[0];
                rsum = 0; r++;
            end
        end
        e_done[last_done] = 1;
        @(negedge clk);
        start = 1; rows = RW'(nrows);
        @(posedge clk);
        @(negedge clk);
        start = 0; rows = '0;
        if (idx_rd) begin
            check(idx_addr == IW'(reads), {tag, " R9 addr"}, int'(idx_addr), reads);
            reads++;
        end
        for (int o = 1; o < last_done + 4; o++) begin
            if (inject && (o == 2 || o == last_done)) begin
                start = 1; rows = RW'(3);
            end
            @(negedge clk);
            if (inject) begin start = 0; rows = '0; end
            if (idx_rd) begin
                if (idx_addr != IW'(reads))
                    check(0, {tag, " R9 addr"}, int'(idx_addr), reads);
                reads++;
            end
            check(out_we == e_we[o], {tag, " R4 we timing"}, int'(out_we), int'(e_we[o]));
            if (e_we[o]) begin
                check(out_addr == e_addr[o], {tag, " R3 row order"}, int'(out_addr), int'(e_addr[o]));
                check(out_bit == e_bit[o], {tag, " R1 R2 row xor"}, int'(out_bit), int'(e_bit[o]));
            end
            check(done == e_done[o], {tag, " R5 R7 done"}, int'(done), int'(e_done[o]));
        end
        check(reads == nent, {tag, " R9 read count"}, reads, nent);
    endtask

    initial begin
        for (int i = 0; i < VEC_LEN; i++) vec_mem[i] = ((i * 5 + 3) % 7) < 3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: idle outputs under reset
        check(!done && !out_we && !idx_rd && !vec_rd, "R8 reset idle",
              int'({done, out_we, idx_rd, vec_rd}), 0);
        rst = 0;
        @(negedge clk);
        check(!done && !out_we && !idx_rd, "R8 after reset", int'({done, out_we, idx_rd}), 0);

        load(4, '{3, 1, 2, 4}, 1);
        run(4, 10, 0, "mixed");
        // R2: every row a single entry, back-to-back row closes
        load(8, '{1, 1, 1, 1, 1, 1, 1, 1}, 2);
        run(8, 8, 0, "single");
        load(1, '{20}, 3);
        run(1, 20, 0, "long");
        load(16, '{1, 4, 2, 1, 3, 1, 5, 2, 1, 1, 6, 2, 3, 1, 4, 2}, 4);
        run(16, 39, 0, "full");
        // R6: extra start pulses during a run and on its done cycle
        load(4, '{3, 1, 2, 4}, 5);
        run(4, 10, 1, "R6 busy");
        // R7: zero rows
        run(0, 0, 0, "R7 empty");
        load(3, '{2, 1, 3}, 6);
        run(3, 6, 0, "after empty");
        finished = 1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule